// File: doc/BRIEF.md
# Stepper Motor Step Sequencer

This block turns a short configuration into a timed run of full steps for a four-coil stepper motor. It takes a 5-bit speed code, an 8-bit step count, a direction bit and a master enable. It drives one coil line at a time and reports whether a run is in progress or has finished. While enable is low, the block copies the configuration inputs into its own registers on every clock. When software raises enable, that copy is frozen and the run begins. Each step waits a number of base ticks set by the speed code. A clock prescaler produces the base tick.

The host writes speed, count and direction with enable at 0, then sets enable to 1. It then polls busy or done. A run ends in one of two ways. The programmed count can run out: done is then set and held until enable returns to 0. Or enable can be cleared early: the motor then stops at the next base tick. In both cases the coil lines keep their last pattern, so the rotor holds its position.

Top module: `stepper_seq`

## Requirements
- R1: After reset, phase_o is 4'b1000, busy_o is 0 and done_o is 0.
- R2: On every clock where enable_i is low, the block captures speed_i, steps_i and dir_i. Changes to those inputs while enable_i is high have no effect on the run in progress: its length, period and direction do not change.
- R3: Code 0 is the fastest speed and code 31 the slowest. One step lasts PRESCALE*(speed+1) clock cycles. The first step takes effect PRESCALE*(speed+1) cycles after the clock edge that samples enable_i high.
- R4: A step count N from 1 to 255 gives exactly N steps. A step count of 0 gives 256 steps.
- R5: The coil pattern cycles 1000 → 0100 → 0010 → 0001 → 1000 when dir is 1, and in the reverse order when dir is 0. Exactly one line of phase_o is high at all times. Bit 3 is the first coil.
- R6: busy_o rises on the clock edge that samples enable_i high from idle. It stays high for the whole run.
- R7: On the edge that makes the last step, busy_o falls and done_o rises. done_o and the final phase pattern then hold while enable_i stays high. done_o clears on the first edge that samples enable_i low.
- R8: If enable_i is low while a run is in progress, the run stops at the next base tick. No further step is made, busy_o falls within PRESCALE cycles, done_o stays 0 and phase_o keeps its value.
- R9: phase_o never changes while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_i | input | SPEED_W | Speed code, 0 fastest |
| steps_i | input | COUNT_W | Step count, 0 means 2^COUNT_W |
| dir_i | input | 1 | 1 forward, 0 reverse |
| enable_i | input | 1 | Master enable: low to configure, high to run |
| phase_o | output | PHASES | One-hot coil drive |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Count exhausted, held until enable low |

## Verification
The bench builds the block with PRESCALE=4 and leaves SPEED_W=5, COUNT_W=8 and PHASES=4 at their defaults. The short base tick keeps the slowest speed code (128 cycles per step) and the 256-step run from a count of 0 within a few thousand cycles. This lets the run length be checked cycle by cycle at both ends of the speed range and at both ends of the count range. With four cycles per tick, an early stop can land between tick boundaries, so the check that busy falls within PRESCALE cycles can tell waiting for the tick apart from stopping at once.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;

endpackage

// File: rtl/stepper_prescaler.sv
module stepper_prescaler #(
    parameter int PRESCALE = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the divider never passes its terminal count
    a_r3_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3: an idle divider restarts from zero
    a_r3_prescale_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/stepper_interval.sv
module stepper_interval #(
    parameter int SPEED_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               tick_i,
    input  logic [SPEED_W-1:0] speed_i,
    output logic               step_o
);
    logic [SPEED_W-1:0] cnt_d, cnt_q;

    always_comb begin
        step_o = tick_i && (cnt_q == speed_i);
        cnt_d  = cnt_q;
        if (!run_i)      cnt_d = '0;
        else if (step_o) cnt_d = '0;
        else if (tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the tick counter never passes the speed code of the run
    a_r3_interval_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> cnt_q <= speed_i);
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq #(
    parameter int PHASES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              fwd_i,
    output logic [PHASES-1:0] phase_o
);
    localparam int IW = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [IW-1:0] TOP = IW'(PHASES - 1);

    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (adv_i) begin
            if (fwd_i) idx_d = (idx_q == TOP) ? '0 : idx_q + 1'b1;
            else       idx_d = (idx_q == '0) ? TOP : idx_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    for (genvar g = 0; g < PHASES; g++) begin : g_coil
        assign phase_o[PHASES-1-g] = (idx_q == IW'(g));
    end

    // R5: exactly one coil is energised
    a_r5_one_coil: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_o) == 1);

    // R5: a forward advance moves the active coil one place toward bit 0
    a_r5_forward_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && fwd_i |=> phase_o == {$past(phase_o[0]), $past(phase_o[PHASES-1:1])});
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq #(
    parameter int PRESCALE = 50000,
    parameter int SPEED_W  = 5,
    parameter int COUNT_W  = 8,
    parameter int PHASES   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SPEED_W-1:0] speed_i,
    input  logic [COUNT_W-1:0] steps_i,
    input  logic               dir_i,
    input  logic               enable_i,
    output logic [PHASES-1:0]  phase_o,
    output logic               busy_o,
    output logic               done_o
);
    import stepper_pkg::*;

    localparam int RW = COUNT_W + 1;
    localparam logic [RW-1:0] FULL_RUN = RW'(1) << COUNT_W;

    typedef struct packed {
        logic [SPEED_W-1:0] speed;
        logic [COUNT_W-1:0] steps;
        logic               dir;
    } cfg_t;

    typedef struct packed {
        run_state_e    st;
        cfg_t          cfg;
        logic [RW-1:0] remain;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic tick, step, adv, running;

    assign running = (ctl_q.st == ST_RUN);

    stepper_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .tick_o (tick)
    );

    stepper_interval #(.SPEED_W(SPEED_W)) u_ivl (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (running),
        .tick_i  (tick),
        .speed_i (ctl_q.cfg.speed),
        .step_o  (step)
    );

    stepper_phase_seq #(.PHASES(PHASES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv),
        .fwd_i   (ctl_q.cfg.dir),
        .phase_o (phase_o)
    );

    always_comb begin
        ctl_d = ctl_q;
        adv   = 1'b0;
        if (!enable_i) begin
            ctl_d.cfg.speed = speed_i;
            ctl_d.cfg.steps = steps_i;
            ctl_d.cfg.dir   = dir_i;
        end
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (enable_i) begin
                    ctl_d.st     = ST_RUN;
                    ctl_d.remain = (ctl_q.cfg.steps == '0) ? FULL_RUN
                                                           : {1'b0, ctl_q.cfg.steps};
                end
            end
            ST_RUN: begin
                if (tick && !enable_i) begin
                    ctl_d.st = ST_IDLE;
                end else if (step) begin
                    adv          = 1'b1;
                    ctl_d.remain = ctl_q.remain - 1'b1;
                    if (ctl_q.remain == RW'(1)) ctl_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                if (!enable_i) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st     <= ST_IDLE;
            ctl_q.cfg    <= '0;
            ctl_q.remain <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o = running;
    assign done_o = (ctl_q.st == ST_DONE);

    // R2: an edge that samples enable high leaves the captured setup untouched
    a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i |=> $stable(ctl_q.cfg));

    // R4: a run never lasts past the end of its step budget
    a_r4_budget_left: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ctl_q.remain != '0);

    // R7: busy and done are never both set
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R7: done is released only after enable was seen low
    a_r7_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> !$past(enable_i));

    // R8: a run ends only on a base tick
    a_r8_stop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(tick));

    // R9: coil pattern holds while no run is active
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(phase_o));
endmodule

// File: tb/stepper_seq_test.sv
module stepper_seq_test;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] speed_i = '0;
    logic [7:0] steps_i = '0;
    logic       dir_i = 1'b0;
    logic       enable_i = 1'b0;
    logic [3:0] phase_o;
    logic       busy_o, done_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int model_idx = 0;

    always #10 clk = ~clk;

    stepper_seq #(.PRESCALE(P), .SPEED_W(5), .COUNT_W(8), .PHASES(4)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .speed_i  (speed_i),
        .steps_i  (steps_i),
        .dir_i    (dir_i),
        .enable_i (enable_i),
        .phase_o  (phase_o),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    typedef struct packed {
        logic [4:0]  spd;
        logic [7:0]  n;
        logic        dir;
        logic [15:0] cyc;
    } vec_t;

    // expected run length = steps * P * (speed + 1)
    localparam vec_t VECS [6] = '{
        '{5'd0,  8'd1, 1'b1, 16'd4},
        '{5'd3,  8'd5, 1'b1, 16'd80},
        '{5'd31, 8'd2, 1'b0, 16'd256},
        '{5'd1,  8'd7, 1'b0, 16'd56},
        '{5'd0,  8'd0, 1'b1, 16'd1024},
        '{5'd7,  8'd4, 1'b1, 16'd128}
    };

    function automatic logic [3:0] pat(input int i);
        return 4'b1000 >> i;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [4:0] spd, input logic [7:0] n, input logic dir,
                           input int exp_cyc, input bit perturb);
        int cnt = 0;
        int nsteps = 0;
        int exp_n = (n == 0) ? 256 : int'(n);
        logic [3:0] prev;
        logic [3:0] held;
        @(negedge clk);
        enable_i = 1'b0;
        speed_i = spd; steps_i = n; dir_i = dir;
        @(posedge clk);
        @(negedge clk);
        enable_i = 1'b1;
        prev = phase_o;
        forever begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (cnt == 1) check("R6 busy rises", int'(busy_o), 1);
            if (perturb && cnt == 2) begin
                speed_i = 5'd31; steps_i = 8'd200; dir_i = ~dir;
            end
            if (phase_o != prev) begin
                model_idx = dir ? (model_idx + 1) % 4 : (model_idx + 3) % 4;
                nsteps++;
                if (phase_o != pat(model_idx))
                    check("R5 sequence", int'(phase_o), int'(pat(model_idx)));
                if (nsteps == 1) check("R3 first step", cnt, exp_cyc / exp_n + 1);
                prev = phase_o;
            end
            if (done_o || cnt > 20000) break;
        end
        check(perturb ? "R2 length unchanged" : "R3 run length", cnt, exp_cyc + 1);
        check("R4 step count", nsteps, exp_n);
        check("R5 final pattern", int'(phase_o), int'(pat(model_idx)));
        check("R7 busy low at end", int'(busy_o), 0);
        held = phase_o;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R7 done held", int'(done_o), 1);
        check("R7 phase held", int'(phase_o), int'(held));
        enable_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7 done clears", int'(done_o), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset phase", int'(phase_o), 8);
        check("R1 reset busy", int'(busy_o), 0);
        check("R1 reset done", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", int'(busy_o), 0);

        foreach (VECS[i])
            run_one(VECS[i].spd, VECS[i].n, VECS[i].dir, int'(VECS[i].cyc), 1'b0);

        // R2: inputs changed mid-run are ignored
        run_one(5'd0, 8'd3, 1'b1, 12, 1'b1);

        // R8: early stop, then R9: no motion while idle
        begin
            int cnt = 0;
            logic [3:0] held;
            @(negedge clk);
            speed_i = 5'd31; steps_i = 8'd10; dir_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            enable_i = 1'b1;
            repeat (200) @(posedge clk);
            @(negedge clk);
            model_idx = (model_idx + 1) % 4;
            check("R3 one step in 200 cycles", int'(phase_o), int'(pat(model_idx)));
            held = phase_o;
            enable_i = 1'b0;
            for (int k = 0; k < 2 * P; k++) begin
                @(posedge clk);
                cnt++;
                @(negedge clk);
                if (!busy_o) break;
            end
            tests = tests + 1;
            if (cnt < 1 || cnt > P || busy_o) begin
                fails = fails + 1;
                $display("FAIL R8 stop delay: actual %0d expected 1..%0d", cnt, P);
            end
            check("R8 done stays low", int'(done_o), 0);
            check("R8 phase kept", int'(phase_o), int'(held));
            repeat (300) @(posedge clk);
            @(negedge clk);
            check("R9 idle phase still", int'(phase_o), int'(held));
            check("R9 idle busy low", int'(busy_o), 0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule